// File: doc/BRIEF.md
# Free-Running Timer with Input Capture and Output Compare

This block holds a 16-bit up-counter that advances on a prescaled tick and serves two event-capture inputs and four match outputs. A capture input is synchronized, checked for the edge its channel is set to watch, and on that edge the counter value is latched into the channel's capture register. A compare channel watches the counter and flips its output pin in the cycle the counter steps onto the channel's compare value.

Overflow, capture and compare events each set a sticky flag. A flag raises its interrupt line when its enable bit is set, and software clears it by writing a one. All configuration goes through a small word-wide register bus. Writes take effect at the clock edge and reads are combinational.

Top module: `frt_capcmp`

## Requirements
- R1: After reset the counter, the capture registers, all flags, all enables, the compare pins and the control register are zero, so the counter is stopped.
- R2: Control register (address 0) bits [1:0] pick the tick rate: 0 gives one count every 2 clocks, 1 every 8, and 2 or 3 every 32. Bit 2 starts the counter, and while bit 2 is 0 the counter holds its value.
- R3: Writing address 0 with bit 3 set zeroes the counter and the prescaler phase at that edge. Bit 3 always reads back as 0.
- R4: When the counter steps from 0xFFFF to 0 it wraps and sets flag bit 0 of the flag register (address 1).
- R5: Capture configuration (address 3) gives channel c a 2-bit field at bits [2c+1:2c]: 0 disables the channel, 1 selects the rising edge, 2 the falling edge, and 3 either edge. A pin change that the field does not select captures nothing and sets no flag.
- R6: The capture input passes through a two-flop synchronizer. On a selected edge, the capture register (address 6+c) receives the counter value present in the cycle the synchronized edge is seen, which is two clocks after the pin changes. The same edge sets flag bit 1+c.
- R7: An enabled compare channel k toggles its pin at the edge where the counter advances to the value in its compare register (address 8+k), and sets flag bit 3+k. Zeroing the counter with the clear bit is not an advance.
- R8: Compare configuration (address 4) holds the enable for channel k in bit k and its initial level in bit 4+k. One cycle after the enable goes from 0 to 1, the pin takes the initial level. A disabled channel holds its pin and sets no flag.
- R9: Flags are sticky. Writing 1 to a bit of address 1 clears that flag, and writing 0 leaves it unchanged.
- R10: Each interrupt output is its flag ANDed with the matching bit of the enable register (address 2), which uses the same bit layout as the flag register.
- R11: Address 5 reads the live counter. Writes to addresses 5, 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational from the address |
| cap_pin_i | input | 2 | Capture inputs, asynchronous |
| cmp_pin_o | output | 4 | Compare outputs |
| irq_ovf_o | output | 1 | Overflow interrupt request |
| irq_cap_o | output | 2 | Capture interrupt requests |
| irq_cmp_o | output | 4 | Compare interrupt requests |

## Verification
The bench keeps a reference model of the counter, prescaler and compare pins, driven by the same bus writes. Each cycle it compares the pins against the model, so a match taken one tick early or late, a toggle repeated on every clock while the counter dwells on a value, or a toggle on a clear shows up as a pin mismatch. Capture tests cover every edge mode on both polarities. A design that captured before the second synchronizer stage, or that ignored its edge setting, would latch a different count or raise a flag where none is due. Directed cases cover the exact tick spacing of each rate, the wrap from 0xFFFF, the initial level loaded on enable, a disabled channel passing its match, write-one-to-clear, masked interrupts and writes to read-only addresses.

// File: rtl/frt_pkg.sv
package frt_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_sel_e;

  localparam int unsigned A_CTRL   = 0;
  localparam int unsigned A_FLAG   = 1;
  localparam int unsigned A_IEN    = 2;
  localparam int unsigned A_CAPCFG = 3;
  localparam int unsigned A_CMPCFG = 4;
  localparam int unsigned A_CNT    = 5;
  localparam int unsigned A_CAP0   = 6;

  localparam int unsigned CTRL_RUN = 2;
  localparam int unsigned CTRL_CLR = 3;
endpackage

// File: rtl/frt_timebase.sv
module frt_timebase #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DIV_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [1:0]       psel_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] next_o,
  output logic             tick_o,
  output logic             ovf_o
);
  logic [DIV_W-1:0] div_q, lim;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    unique case (psel_i)
      2'd0:    lim = DIV_W'(1);
      2'd1:    lim = DIV_W'(7);
      default: lim = DIV_W'(31);
    endcase
  end

  assign tick_o = run_i & ~clr_i & (div_q == lim);
  assign next_o = cnt_q + 1'b1;
  assign ovf_o  = tick_o & (&cnt_q);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (run_i) begin
      if (tick_o) begin
        div_q <= '0;
        cnt_q <= next_o;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/frt_capture.sv
module frt_capture
  import frt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  edge_sel_e        mode_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             evt_o
);
  // [1:0] synchronizer, [2] previous synchronized level
  logic [2:0] sync_q;
  logic       rise, fall;

  assign rise = sync_q[1] & ~sync_q[2];
  assign fall = ~sync_q[1] & sync_q[2];

  always_comb begin
    unique case (mode_i)
      EDGE_OFF:  evt_o = 1'b0;
      EDGE_RISE: evt_o = rise;
      EDGE_FALL: evt_o = fall;
      EDGE_BOTH: evt_o = rise | fall;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      cap_o  <= '0;
    end else begin
      sync_q <= {sync_q[1:0], pin_i};
      if (evt_o) cap_o <= cnt_i;
    end
  end
endmodule

// File: rtl/frt_compare.sv
module frt_compare #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic             init_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] next_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             pin_o,
  output logic             evt_o
);
  // load cycle excluded so an enable never coincides with a toggle
  assign evt_o = en_i & ~load_i & tick_i & (next_i == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pin_o <= 1'b0;
    else if (load_i) pin_o <= init_i;
    else if (evt_o)  pin_o <= ~pin_o;
  end
endmodule

// File: rtl/frt_capcmp.sv
module frt_capcmp
  import frt_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned N_CAP  = 2,
  parameter int unsigned N_CMP  = 4,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  input  logic [N_CAP-1:0]  cap_pin_i,
  output logic [N_CMP-1:0]  cmp_pin_o,
  output logic              irq_ovf_o,
  output logic [N_CAP-1:0]  irq_cap_o,
  output logic [N_CMP-1:0]  irq_cmp_o
);
  localparam int unsigned FLG_W    = 1 + N_CAP + N_CMP;
  localparam int unsigned CMP_LO   = 1 + N_CAP;
  localparam int unsigned CMP_BASE = A_CAP0 + N_CAP;

  logic [2:0]                  ctrl_q;
  logic [FLG_W-1:0]            ien_q, flag_q, w1c, evt;
  logic [2*N_CAP-1:0]          capcfg_q;
  logic [2*N_CMP-1:0]          cmpcfg_q;
  logic [N_CMP-1:0]            en_q, load;
  logic [N_CMP-1:0][CNT_W-1:0] cmp_q;
  logic [N_CAP-1:0][CNT_W-1:0] cap_val;
  logic [N_CAP-1:0]            cap_evt;
  logic [N_CMP-1:0]            cmp_evt;
  logic [CNT_W-1:0]            cnt_q, cnt_next;
  logic                        tick, ovf_evt, clr;

  function automatic logic hit(input int unsigned a);
    return bus_we_i && (bus_addr_i == ADDR_W'(a));
  endfunction

  assign clr  = hit(A_CTRL) && bus_wdata_i[CTRL_CLR];
  assign w1c  = hit(A_FLAG) ? bus_wdata_i[FLG_W-1:0] : '0;
  assign load = cmpcfg_q[N_CMP-1:0] & ~en_q;
  assign evt  = {cmp_evt, cap_evt, ovf_evt};

  frt_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk_i, .rst_ni,
    .run_i (ctrl_q[CTRL_RUN]),
    .psel_i(ctrl_q[1:0]),
    .clr_i (clr),
    .cnt_o (cnt_q),
    .next_o(cnt_next),
    .tick_o(tick),
    .ovf_o (ovf_evt)
  );

  for (genvar c = 0; c < N_CAP; c++) begin : g_cap
    frt_capture #(.CNT_W(CNT_W)) u_cap (
      .clk_i, .rst_ni,
      .pin_i (cap_pin_i[c]),
      .mode_i(edge_sel_e'(capcfg_q[2*c +: 2])),
      .cnt_i (cnt_q),
      .cap_o (cap_val[c]),
      .evt_o (cap_evt[c])
    );
  end

  for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
    frt_compare #(.CNT_W(CNT_W)) u_cmp (
      .clk_i, .rst_ni,
      .en_i  (cmpcfg_q[k]),
      .load_i(load[k]),
      .init_i(cmpcfg_q[N_CMP+k]),
      .tick_i(tick),
      .next_i(cnt_next),
      .cmp_i (cmp_q[k]),
      .pin_o (cmp_pin_o[k]),
      .evt_o (cmp_evt[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      ien_q    <= '0;
      flag_q   <= '0;
      capcfg_q <= '0;
      cmpcfg_q <= '0;
      en_q     <= '0;
      cmp_q    <= '0;
    end else begin
      flag_q <= (flag_q & ~w1c) | evt;
      en_q   <= cmpcfg_q[N_CMP-1:0];
      if (hit(A_CTRL))   ctrl_q   <= bus_wdata_i[2:0];
      if (hit(A_IEN))    ien_q    <= bus_wdata_i[FLG_W-1:0];
      if (hit(A_CAPCFG)) capcfg_q <= bus_wdata_i[2*N_CAP-1:0];
      if (hit(A_CMPCFG)) cmpcfg_q <= bus_wdata_i[2*N_CMP-1:0];
      for (int k = 0; k < N_CMP; k++)
        if (hit(CMP_BASE + k)) cmp_q[k] <= bus_wdata_i;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_W'(A_CTRL))   bus_rdata_o[2:0]         = ctrl_q;
    if (bus_addr_i == ADDR_W'(A_FLAG))   bus_rdata_o[FLG_W-1:0]   = flag_q;
    if (bus_addr_i == ADDR_W'(A_IEN))    bus_rdata_o[FLG_W-1:0]   = ien_q;
    if (bus_addr_i == ADDR_W'(A_CAPCFG)) bus_rdata_o[2*N_CAP-1:0] = capcfg_q;
    if (bus_addr_i == ADDR_W'(A_CMPCFG)) bus_rdata_o[2*N_CMP-1:0] = cmpcfg_q;
    if (bus_addr_i == ADDR_W'(A_CNT))    bus_rdata_o              = cnt_q;
    for (int c = 0; c < N_CAP; c++)
      if (bus_addr_i == ADDR_W'(A_CAP0 + c)) bus_rdata_o = cap_val[c];
    for (int k = 0; k < N_CMP; k++)
      if (bus_addr_i == ADDR_W'(CMP_BASE + k)) bus_rdata_o = cmp_q[k];
  end

  assign irq_ovf_o = flag_q[0] & ien_q[0];
  assign irq_cap_o = flag_q[CMP_LO-1:1] & ien_q[CMP_LO-1:1];
  assign irq_cmp_o = flag_q[FLG_W-1:CMP_LO] & ien_q[FLG_W-1:CMP_LO];
endmodule

// File: rtl/frt_capcmp_chk.sv
module frt_capcmp_chk #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned N_CAP = 2,
  parameter int unsigned N_CMP = 4,
  parameter int unsigned FLG_W = 7
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        tick,
  input logic                        clr,
  input logic                        ovf,
  input logic [CNT_W-1:0]            cnt,
  input logic [N_CMP-1:0]            load,
  input logic [N_CMP-1:0]            cmp_pin,
  input logic [FLG_W-1:0]            flag,
  input logic [FLG_W-1:0]            w1c,
  input logic [N_CAP-1:0]            cap_evt,
  input logic [N_CAP-1:0][CNT_W-1:0] cap_val
);
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> cnt == $past(cnt) + 1'b1);                                   // R2
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick && !clr) |=> $stable(cnt));                                    // R2
  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> cnt == '0);                                                   // R3
  AST_OVF_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf |=> flag[0]);                                                     // R4
  AST_CAP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_evt == '0) |=> $stable(cap_val));                                // R6
  AST_CMP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick && load == '0) |=> $stable(cmp_pin));                          // R7
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w1c == '0) |=> ((flag & $past(flag)) == $past(flag)));               // R9
endmodule

bind frt_capcmp frt_capcmp_chk #(
  .CNT_W(CNT_W), .N_CAP(N_CAP), .N_CMP(N_CMP), .FLG_W(FLG_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick   (tick),
  .clr    (clr),
  .ovf    (ovf_evt),
  .cnt    (cnt_q),
  .load   (load),
  .cmp_pin(cmp_pin_o),
  .flag   (flag_q),
  .w1c    (w1c),
  .cap_evt(cap_evt),
  .cap_val(cap_val)
);

// File: tb/tb_frt_capcmp.sv
module tb_frt_capcmp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  cap_pin = '0;
  logic [3:0]  cmp_pin;
  logic        irq_ovf;
  logic [1:0]  irq_cap;
  logic [3:0]  irq_cmp;

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;

  always #10 clk = ~clk;

  frt_capcmp dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .cap_pin_i(cap_pin),
    .cmp_pin_o(cmp_pin), .irq_ovf_o(irq_ovf), .irq_cap_o(irq_cap),
    .irq_cmp_o(irq_cmp)
  );

  // reference model of counter, prescaler and compare pins
  logic [15:0] m_cnt, m_nx;
  logic [4:0]  m_div, m_lim;
  logic        m_run, m_tick, m_clr;
  logic [1:0]  m_psel;
  logic [7:0]  m_cfg;
  logic [3:0]  m_enq, m_pin;
  logic [15:0] m_cmp [4];
  logic [3:0]  m_capcfg = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = '0; m_div = '0; m_run = 1'b0; m_psel = '0;
      m_cfg = '0; m_enq = '0; m_pin = '0;
      for (int k = 0; k < 4; k++) m_cmp[k] = '0;
    end else begin
      m_clr  = we && addr == 4'd0 && wdata[3];
      m_lim  = (m_psel == 2'd0) ? 5'd1 : (m_psel == 2'd1) ? 5'd7 : 5'd31;
      m_tick = m_run && m_div == m_lim && !m_clr;
      m_nx   = m_cnt + 16'd1;
      for (int k = 0; k < 4; k++) begin
        if (m_cfg[k] && !m_enq[k]) m_pin[k] = m_cfg[4+k];
        else if (m_cfg[k] && m_tick && m_nx == m_cmp[k]) m_pin[k] = ~m_pin[k];
      end
      m_enq = m_cfg[3:0];
      if (m_clr) begin
        m_cnt = '0; m_div = '0;
      end else if (m_run) begin
        if (m_tick) begin m_div = '0; m_cnt = m_nx; end
        else m_div = m_div + 5'd1;
      end
      if (we) begin
        if (addr == 4'd0) begin m_run = wdata[2]; m_psel = wdata[1:0]; end
        if (addr == 4'd4) m_cfg = wdata[7:0];
        if (addr >= 4'd8 && addr <= 4'd11) m_cmp[addr-4'd8] = wdata;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) chk("R7/R8 compare pins vs model", 32'(cmp_pin), 32'(m_pin));
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic bit cap_expected(input logic [1:0] cfg, input logic prev, input logic nv);
    if (prev == nv) return 1'b0;
    case (cfg)
      2'd1: return nv;
      2'd2: return !nv;
      2'd3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // R5/R6: drive one capture pin and check the capture register and flag
  task automatic cap_event(input int c, input logic nv);
    logic [15:0] old_v, exp_v, new_v, flg;
    bit hit;
    hit = cap_expected(m_capcfg[2*c +: 2], cap_pin[c], nv);
    wr(4'd1, 16'h007F);
    rd(4'(6 + c), old_v);
    cap_pin[c] = nv;
    @(posedge clk); @(posedge clk); @(negedge clk);
    exp_v = m_cnt;
    @(posedge clk); @(negedge clk);
    rd(4'(6 + c), new_v);
    rd(4'd1, flg);
    if (hit) begin
      chk("R6 captured count", 32'(new_v), 32'(exp_v));
      chk("R6 capture flag", 32'(flg[1+c]), 32'd1);
      chk("R10 capture irq", 32'(irq_cap[c]), 32'd1);
    end else begin
      chk("R5 unselected edge keeps capture", 32'(new_v), 32'(old_v));
      chk("R5 unselected edge no flag", 32'(flg[1+c]), 32'd0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v, tgt;
    int seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;

    // R1 reset state
    rd(4'd0, v); chk("R1 control after reset", 32'(v), 32'd0);
    rd(4'd5, v); chk("R1 counter after reset", 32'(v), 32'd0);
    rd(4'd1, v); chk("R1 flags after reset", 32'(v), 32'd0);
    rd(4'd6, v); chk("R1 capture0 after reset", 32'(v), 32'd0);
    rd(4'd7, v); chk("R1 capture1 after reset", 32'(v), 32'd0);
    chk("R1 pins after reset", 32'(cmp_pin), 32'd0);
    idle(10);
    rd(4'd5, v); chk("R1 counter stopped", 32'(v), 32'd0);

    // R2/R3 tick spacing per rate, measured from a clear
    wr(4'd0, 16'h000C); idle(4);  rd(4'd5, v); chk("R2 divide by 2", 32'(v), 32'd2);
    rd(4'd0, v); chk("R3 clear bit reads 0", 32'(v), 32'h4);
    wr(4'd0, 16'h000D); idle(16); rd(4'd5, v); chk("R2 divide by 8", 32'(v), 32'd2);
    wr(4'd0, 16'h000E); idle(64); rd(4'd5, v); chk("R2 divide by 32 sel 2", 32'(v), 32'd2);
    wr(4'd0, 16'h000F); idle(64); rd(4'd5, v); chk("R2 divide by 32 sel 3", 32'(v), 32'd2);
    wr(4'd0, 16'h0001); rd(4'd5, tgt); idle(40); rd(4'd5, v);
    chk("R2 stopped counter holds", 32'(v), 32'(tgt));
    wr(4'd0, 16'h0008); rd(4'd5, v); chk("R3 clear while stopped", 32'(v), 32'd0);

    // R11 read-only addresses
    wr(4'd0, 16'h0004); idle(7);
    wr(4'd5, 16'hBEEF); rd(4'd5, v); chk("R11 counter write ignored", 32'(v), 32'(m_cnt));
    wr(4'd6, 16'h1234); rd(4'd6, v); chk("R11 capture write ignored", 32'(v), 32'd0);

    wr(4'd2, 16'h007F);

    // R5/R6 edge modes: ch0 rising, ch1 falling
    m_capcfg = 4'b1001; wr(4'd3, 16'(m_capcfg));
    cap_event(0, 1'b1);
    cap_event(0, 1'b0);
    cap_event(1, 1'b1);
    cap_event(1, 1'b0);
    m_capcfg = 4'b0011; wr(4'd3, 16'(m_capcfg));
    cap_event(0, 1'b1);
    cap_event(0, 1'b0);
    cap_event(1, 1'b1);
    cap_event(1, 1'b0);

    // R8 enable loads initial level; R7 match toggles and flags
    wr(4'd0, 16'h000C);
    wr(4'd4, 16'h0011); idle(1);
    chk("R8 initial level loaded", 32'(cmp_pin[0]), 32'd1);
    wr(4'd1, 16'h007F);
    tgt = m_cnt + 16'd8;
    wr(4'd8, tgt);
    wr(4'd11, tgt);
    while (m_cnt != tgt) @(negedge clk);
    chk("R7 pin toggled at match", 32'(cmp_pin[0]), 32'd0);
    rd(4'd1, v);
    chk("R7 compare flag", 32'(v[3]), 32'd1);
    chk("R8 disabled channel no flag", 32'(v[6]), 32'd0);
    chk("R8 disabled channel pin held", 32'(cmp_pin[3]), 32'd0);
    chk("R10 compare irq", 32'(irq_cmp[0]), 32'd1);
    wr(4'd2, 16'h0000);
    chk("R10 masked irq", 32'(irq_cmp[0]), 32'd0);
    rd(4'd1, v); chk("R9 flag survives mask", 32'(v[3]), 32'd1);
    wr(4'd1, 16'h0000); rd(4'd1, v); chk("R9 write 0 keeps flag", 32'(v[3]), 32'd1);
    wr(4'd1, 16'h0008); rd(4'd1, v); chk("R9 write 1 clears flag", 32'(v[3]), 32'd0);
    wr(4'd2, 16'h007F);

    // random mix of rates, compare settings and capture edges
    for (int it = 0; it < 40; it++) begin
      wr(4'd0, 16'h0004 | 16'($urandom % 4));
      wr(4'd4, 16'($urandom % 256));
      for (int k = 0; k < 4; k++) wr(4'(8 + k), m_cnt + 16'd1 + 16'($urandom % 24));
      m_capcfg = 4'($urandom % 16); wr(4'd3, 16'(m_capcfg));
      cap_event(int'($urandom % 2), 1'($urandom % 2));
      idle(int'($urandom % 60));
      rd(4'd5, v); chk("R2 counter vs model", 32'(v), 32'(m_cnt));
    end

    // R4 wrap from 0xFFFF
    wr(4'd0, 16'h000C);
    wr(4'd1, 16'h007F);
    while (m_cnt != 16'hFFFF) @(negedge clk);
    rd(4'd1, v); chk("R4 no flag before wrap", 32'(v[0]), 32'd0);
    while (m_cnt != 16'h0000) @(negedge clk);
    rd(4'd1, v); chk("R4 overflow flag", 32'(v[0]), 32'd1);
    chk("R10 overflow irq", 32'(irq_ovf), 32'd1);
    rd(4'd5, v); chk("R4 counter wrapped", 32'(v), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule